// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block collects fifteen interrupt levels, numbered 1 to 15, into one pending state. It then presents the processor with a single 4-bit request: the highest-numbered level that is pending and not masked. The request is zero when no eligible level exists. Four sources are internal: a real-time clock tick, a general-purpose timer tick, and one event line for each of two serial channels. The serial channels raise their level after every character received or transmitted. Any level can also be driven directly by a one-cycle pulse on a general request vector.

Software reaches the block through a simple word-addressed port. The port gives access to a mask register, a write-one-to-clear register and a force register, which raises levels for test. It also gives a read view of what is pending and a shape register that is kept but has no effect. When the processor takes an interrupt, it acknowledges with the served level number. This clears both the pending bit and the force bit of that level.

The request output is decoded from registered state with combinational logic only. A write or a source pulse therefore shows up in the request in the cycle after the clock edge that captures it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all pending bits, force bits and shape bits are 0. All mask bits for levels 1 to 15 are 1, and `irq_level` is 0.
- R2: A high cycle on `rtc_tick` sets pending bit 12, on `gpt_tick` bit 10, on `uart_a_evt` bit 4, on `uart_b_evt` bit 5, and on `ext_req[n]` bit n. The bit reads back as set after the next clock edge.
- R3: A write to the clear register (byte offset 0x50) resets each pending bit and force bit whose data bit is 1. Bits whose data bit is 0 are left unchanged. If a source pulse for a level arrives in the same cycle as the clear, the level stays pending.
- R4: A mask bit of 1 (mask register at 0x4C) keeps that level out of `irq_level`. The pending read view still records the event.
- R5: `irq_level` equals the highest level n for which (pending or force) is 1 and mask is 0. It is 0 when no level meets this.
- R6: A write to the force register (0x54) loads the force bits. A forced level counts as pending for `irq_level` and the pending view, whether or not a source fired. A force write takes precedence over a same-cycle acknowledge or clear of that bit.
- R7: With `ack_valid` high, `ack_level` = n (1 to 15) clears pending bit n and force bit n, unless a source pulse for level n arrives in the same cycle. An acknowledge of level 0 changes nothing.
- R8: The shape register (0x44) reads back what was written to it and has no effect on `irq_level` or on any other register.
- R9: In the register map, bit n of each register corresponds to level n. Byte offset 0x48 reads (pending OR force) and ignores writes. 0x50 reads 0. Bit 0, bits 16 and up, and every unmapped offset read 0. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 15 | Per-level request pulses, bit n drives level n (vector index 15 down to 1) |
| rtc_tick | input | 1 | Real-time clock tick, level 12 |
| gpt_tick | input | 1 | General-purpose timer tick, level 10 |
| uart_a_evt | input | 1 | Serial channel A character event, level 4 |
| uart_b_evt | input | 1 | Serial channel B character event, level 5 |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest eligible level, 0 if none |

## Verification
Directed steps first check the reset view. They then check collisions between a source pulse and a clear or an acknowledge in the same cycle, an acknowledge of level 0, and writes to the read-only pending offset. These separate a set-wins design from a clear-wins design and show whether an acknowledge wrongly reaches its neighbours. A seeded random phase follows. It mixes sparse source pulses, writes to every offset including unmapped ones, and acknowledges of both the current level and arbitrary levels. The bench compares the request and the addressed read data every cycle against a model. That model catches wrong priority order, mask polarity, force handling and register decoding.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_LEVELS = 15;
    localparam int LEVEL_W    = $clog2(NUM_LEVELS + 1);

    localparam logic [5:0] WIDX_SHAPE = 6'h11;
    localparam logic [5:0] WIDX_PEND  = 6'h12;
    localparam logic [5:0] WIDX_MASK  = 6'h13;
    localparam logic [5:0] WIDX_CLEAR = 6'h14;
    localparam logic [5:0] WIDX_FORCE = 6'h15;

    typedef enum logic [2:0] {
        SEL_SHAPE,
        SEL_PEND,
        SEL_MASK,
        SEL_CLEAR,
        SEL_FORCE,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [5:0] widx);
        unique case (widx)
            WIDX_SHAPE: return SEL_SHAPE;
            WIDX_PEND:  return SEL_PEND;
            WIDX_MASK:  return SEL_MASK;
            WIDX_CLEAR: return SEL_CLEAR;
            WIDX_FORCE: return SEL_FORCE;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map #(
    parameter int NLEV    = 15,
    parameter int RTC_LVL = 12,
    parameter int GPT_LVL = 10,
    parameter int UA_LVL  = 4,
    parameter int UB_LVL  = 5
) (
    input  logic [NLEV:1] ext_req,
    input  logic          rtc_tick,
    input  logic          gpt_tick,
    input  logic          uart_a_evt,
    input  logic          uart_b_evt,
    output logic [NLEV:1] src_vec
);
    for (genvar i = 1; i <= NLEV; i++) begin : g_lvl
        logic internal_hit;
        assign internal_hit = ((i == RTC_LVL) && rtc_tick)
                            | ((i == GPT_LVL) && gpt_tick)
                            | ((i == UA_LVL)  && uart_a_evt)
                            | ((i == UB_LVL)  && uart_b_evt);
        assign src_vec[i] = ext_req[i] | internal_hit;
    end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int NLEV = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NLEV:1] src_vec,
    input  logic [NLEV:1] kill_vec,
    input  logic          frc_we,
    input  logic [NLEV:1] frc_wval,
    output logic [NLEV:1] pend_q,
    output logic [NLEV:1] force_q
);
    logic [NLEV:1] pend_d;
    logic [NLEV:1] force_d;

    always_comb begin
        pend_d  = (pend_q & ~kill_vec) | src_vec;
        force_d = frc_we ? frc_wval : (force_q & ~kill_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            force_q <= '0;
        end else begin
            pend_q  <= pend_d;
            force_q <= force_d;
        end
    end

    // R2: every pulsing source is recorded
    p_src_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_vec != '0) |=> ((pend_q & $past(src_vec)) == $past(src_vec)));

    // R3 / R7: a kill without a competing pulse empties the bit
    p_kill_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((kill_vec & ~src_vec) != '0) |=> ((pend_q & $past(kill_vec & ~src_vec)) == '0));

    // R7: acknowledge also drops the force bit unless software rewrote it
    p_kill_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc_we && kill_vec != '0) |=> ((force_q & $past(kill_vec)) == '0));

    // R6: a force write lands unchanged
    p_force_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frc_we |=> (force_q == $past(frc_wval)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NLEV = 15,
    parameter int LW   = 4
) (
    input  logic [NLEV:1] elig,
    output logic [LW-1:0] level
);
    always_comb begin
        level = '0;
        for (int i = 1; i <= NLEV; i++) begin
            if (elig[i]) level = LW'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NLEV    = NUM_LEVELS,
    parameter int LW      = LEVEL_W,
    parameter int DW      = 32,
    parameter int AW      = 8,
    parameter int RTC_LVL = 12,
    parameter int GPT_LVL = 10,
    parameter int UA_LVL  = 4,
    parameter int UB_LVL  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NLEV:1] ext_req,
    input  logic          rtc_tick,
    input  logic          gpt_tick,
    input  logic          uart_a_evt,
    input  logic          uart_b_evt,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ack_valid,
    input  logic [LW-1:0] ack_level,
    output logic [LW-1:0] irq_level
);
    reg_sel_e      sel;
    logic [NLEV:1] src_vec;
    logic [NLEV:1] ack_vec;
    logic [NLEV:1] clr_vec;
    logic [NLEV:1] kill_vec;
    logic [NLEV:1] pend_q;
    logic [NLEV:1] force_q;
    logic [NLEV:1] mask_q;
    logic [NLEV:1] shape_q;
    logic [NLEV:1] active;
    logic [NLEV:1] elig;
    logic [NLEV:1] wfield;

    assign sel    = decode_sel(reg_addr[7:2]);
    assign wfield = reg_wdata[NLEV:1];

    irq_src_map #(
        .NLEV(NLEV), .RTC_LVL(RTC_LVL), .GPT_LVL(GPT_LVL),
        .UA_LVL(UA_LVL), .UB_LVL(UB_LVL)
    ) u_map (
        .ext_req(ext_req), .rtc_tick(rtc_tick), .gpt_tick(gpt_tick),
        .uart_a_evt(uart_a_evt), .uart_b_evt(uart_b_evt), .src_vec(src_vec)
    );

    for (genvar i = 1; i <= NLEV; i++) begin : g_ack
        assign ack_vec[i] = ack_valid && (ack_level == LW'(i));
    end

    assign clr_vec  = (reg_wr && sel == SEL_CLEAR) ? wfield : '0;
    assign kill_vec = clr_vec | ack_vec;

    irq_pending_bank #(.NLEV(NLEV)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .kill_vec(kill_vec),
        .frc_we(reg_wr && sel == SEL_FORCE), .frc_wval(wfield),
        .pend_q(pend_q), .force_q(force_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            shape_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_MASK)  mask_q  <= wfield;
            if (sel == SEL_SHAPE) shape_q <= wfield;
        end
    end

    assign active = pend_q | force_q;
    assign elig   = active & ~mask_q;

    irq_prio_enc #(.NLEV(NLEV), .LW(LW)) u_enc (
        .elig(elig), .level(irq_level)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_SHAPE: reg_rdata[NLEV:1] = shape_q;
            SEL_PEND:  reg_rdata[NLEV:1] = active;
            SEL_MASK:  reg_rdata[NLEV:1] = mask_q;
            SEL_FORCE: reg_rdata[NLEV:1] = force_q;
            SEL_CLEAR, SEL_NONE: reg_rdata = '0;
        endcase
    end

    // R4: a reported level is never masked
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> !mask_q[irq_level]);

    // R5: a reported level is really pending or forced
    p_level_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> active[irq_level]);

    // R5: nothing eligible means no request
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> (irq_level == '0));

    // R9: the clear offset never returns data
    p_clear_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[7:2] == WIDX_CLEAR) |-> (reg_rdata == '0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:1] ext_req = '0;
    logic        rtc_tick = 0, gpt_tick = 0, uart_a_evt = 0, uart_b_evt = 0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ack_valid = 0;
    logic [3:0]  ack_level = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:1] m_pend, m_force, m_mask, m_shape;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .rtc_tick(rtc_tick),
        .gpt_tick(gpt_tick), .uart_a_evt(uart_a_evt), .uart_b_evt(uart_b_evt),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
        .irq_level(irq_level)
    );

    function automatic logic [3:0] exp_level();
        logic [15:1] e = (m_pend | m_force) & ~m_mask;
        for (int i = 15; i >= 1; i--) if (e[i]) return 4'(i);
        return 4'd0;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [7:0] a);
        logic [31:0] r = '0;
        case (a[7:2])
            6'h11: r[15:1] = m_shape;
            6'h12: r[15:1] = m_pend | m_force;
            6'h13: r[15:1] = m_mask;
            6'h15: r[15:1] = m_force;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pend = '0; m_force = '0; m_mask = '1; m_shape = '0;
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input string tag, input logic [15:1] ext, input logic rtc,
                       input logic gpt, input logic ua, input logic ub,
                       input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic av, input logic [3:0] al);
        logic [15:1] src, kill, clr, ackv;
        ext_req = ext; rtc_tick = rtc; gpt_tick = gpt; uart_a_evt = ua; uart_b_evt = ub;
        reg_wr = wr; reg_addr = a; reg_wdata = d; ack_valid = av; ack_level = al;
        src = ext;
        if (rtc) src[12] = 1'b1;
        if (gpt) src[10] = 1'b1;
        if (ua)  src[4]  = 1'b1;
        if (ub)  src[5]  = 1'b1;
        clr  = (wr && a[7:2] == 6'h14) ? d[15:1] : '0;
        ackv = '0;
        if (av && al != 0) ackv[al] = 1'b1;
        kill = clr | ackv;
        @(posedge clk);
        m_pend = (m_pend & ~kill) | src;
        if (wr && a[7:2] == 6'h15) m_force = d[15:1];
        else m_force = m_force & ~kill;
        if (wr && a[7:2] == 6'h13) m_mask  = d[15:1];
        if (wr && a[7:2] == 6'h11) m_shape = d[15:1];
        @(negedge clk);
        reg_wr = 0; ack_valid = 0; ext_req = '0;
        rtc_tick = 0; gpt_tick = 0; uart_a_evt = 0; uart_b_evt = 0;
        check({tag, " irq_level"}, 32'(irq_level), 32'(exp_level()));
        check({tag, " rdata"}, reg_rdata, exp_rdata(reg_addr));
    endtask

    task automatic idle(input string tag, input logic [7:0] a);
        cyc(tag, '0, 0, 0, 0, 0, 0, a, '0, 0, '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [8];
        void'($urandom(32'h1F2E3D4C));
        addrs = '{8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h40, 8'h58, 8'h4D};
        model_reset();
        repeat (4) @(negedge clk);
        // R1: reset state through each offset
        for (int k = 0; k < 5; k++) begin
            reg_addr = addrs[k]; #0.5;
            check("R1 reset rdata", reg_rdata, exp_rdata(reg_addr));
        end
        check("R1 reset irq_level", 32'(irq_level), 32'd0);
        rst_n = 1;
        idle("R1", 8'h4C);

        // R2/R4: masked sources still recorded, no request
        cyc("R4 masked rtc", '0, 1, 0, 0, 0, 0, 8'h48, '0, 0, '0);
        check("R4 masked irq", 32'(irq_level), 32'd0);
        cyc("R9 unmask", '0, 0, 0, 0, 0, 1, 8'h4C, 32'h0, 0, '0);
        check("R5 rtc level", 32'(irq_level), 32'd12);
        cyc("R2 uart_a", '0, 0, 0, 1, 0, 0, 8'h48, '0, 0, '0);
        cyc("R2 uart_b gpt", '0, 0, 1, 0, 1, 0, 8'h48, '0, 0, '0);
        check("R2 pend view", reg_rdata, 32'h0000_1430);

        // R3: clear against same-cycle pulse, then alone
        cyc("R3 clear vs pulse", '0, 1, 0, 0, 0, 1, 8'h50, 32'h1000, 0, '0);
        check("R3 pulse wins", 32'(irq_level), 32'd12);
        cyc("R3 clear", '0, 0, 0, 0, 0, 1, 8'h50, 32'h1000, 0, '0);
        check("R3 cleared", 32'(irq_level), 32'd10);
        idle("R3 view", 8'h48);

        // R7: ack, ack vs pulse, ack of level 0
        cyc("R7 ack 10", '0, 0, 0, 0, 0, 0, 8'h48, '0, 1, 4'd10);
        check("R7 after ack", 32'(irq_level), 32'd5);
        cyc("R7 ack vs pulse", 15'h0010, 0, 0, 0, 0, 0, 8'h48, '0, 1, 4'd5);
        cyc("R7 ack vs pulse2", 15'h0010, 0, 0, 0, 0, 0, 8'h48, '0, 1, 4'd5);
        check("R7 pulse wins", 32'(irq_level), 32'd5);
        cyc("R7 ack zero", '0, 0, 0, 0, 0, 0, 8'h48, '0, 1, 4'd0);
        check("R7 ack zero view", reg_rdata, 32'h0000_0030);

        // R6: force raises a level; ack removes the force bit
        cyc("R6 force 15", '0, 0, 0, 0, 0, 1, 8'h54, 32'h8000, 0, '0);
        check("R6 forced", 32'(irq_level), 32'd15);
        cyc("R7 ack forced", '0, 0, 0, 0, 0, 0, 8'h54, '0, 1, 4'd15);
        check("R7 force dropped", reg_rdata, 32'h0);
        cyc("R6 force vs ack", '0, 0, 0, 0, 0, 1, 8'h54, 32'h0000_0200, 1, 4'd9);
        check("R6 write wins", reg_rdata, 32'h0000_0200);

        // R8: shape writes change nothing else
        cyc("R8 shape", '0, 0, 0, 0, 0, 1, 8'h44, 32'hFFFF_FFFF, 0, '0);
        check("R8 readback", reg_rdata, 32'h0000_FFFE);
        check("R8 irq same", 32'(irq_level), 32'd9);

        // R9: pending offset ignores writes; unmapped read zero
        cyc("R9 pend write", '0, 0, 0, 0, 0, 1, 8'h48, 32'hFFFF_FFFF, 0, '0);
        idle("R9 unmapped", 8'h58);
        idle("R9 clear read", 8'h50);

        // random phase: R2 R3 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 3000; n++) begin
            logic [15:1] ext;
            logic        wr, av;
            logic [7:0]  a;
            logic [31:0] d;
            logic [3:0]  al;
            ext = 15'($urandom & $urandom & $urandom & $urandom);
            wr  = ($urandom_range(0, 9) < 3);
            a   = addrs[$urandom_range(0, 7)];
            d   = $urandom;
            if (a == 8'h54 || a == 8'h50) d = d & $urandom & $urandom;
            av  = ($urandom_range(0, 4) == 0);
            al  = ($urandom_range(0, 1) == 0) ? exp_level() : 4'($urandom_range(0, 15));
            cyc("R5 random", ext, $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
                $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, wr, a, d, av, al);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule